// File: doc/BRIEF.md
# Iterative Half-Adder Feedback Adder

This block adds two unsigned words using a single half adder per bit position instead of a full-adder carry chain. Operands are captured into two working registers. On every clock cycle each bit position forms the XOR and the AND of its two current operand bits. The XOR word becomes the new first operand. The AND word, moved up by one position with a zero entering at bit 0, becomes the new second operand. When the second operand reaches zero, no carries remain and the first operand register holds the sum. Latency therefore depends on the data. The longest carry propagation sets the number of cycles: at most the word width, and on average close to the base-2 logarithm of the width.

A computation starts on a falling edge of the active-low start input while the block is idle. The busy output rises on the cycle after the operands are captured and falls when completion is detected. The sum, the sticky carry-out and the iteration count are registered. They stay valid until the next start.

Top module: `hfa_adder`

## Requirements
- R1: After reset, busy, sum, cout and iter_cnt are all 0.
- R2: A falling edge of start_n, sampled while busy is 0, captures op_a and op_b. On the next cycle busy is 1, iter_cnt is 0 and cout is 0.
- R3: When busy falls, sum equals (op_a + op_b) modulo 2^WIDTH for the captured operands.
- R4: When busy falls, cout is 1 exactly when op_a + op_b overflows WIDTH bits. cout is cleared by every new load.
- R5: iter_cnt counts the cycles in which the working second operand was nonzero: 0x7F + 0x01 at 8 bits gives 8, 0x05 + 0x0A gives 1.
- R6: busy stays 1 for exactly iter_cnt + 1 cycles after the load edge, then falls to 0.
- R7: With op_b equal to 0 at load, busy is 1 for a single cycle, iter_cnt is 0 and sum equals op_a.
- R8: While busy is 1, changes on op_a and op_b and new falling edges of start_n have no effect on the running result.
- R9: While busy is 0 and start_n is 1, sum, cout and iter_cnt hold their values.
- R10: iter_cnt never exceeds WIDTH. 0xFF + 0x01 at 8 bits takes exactly 8 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Active-low start; a falling edge while idle loads the operands |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| busy | output | 1 | High while the computation runs; falls on completion |
| sum | output | WIDTH | Result word, valid once busy has fallen |
| cout | output | 1 | Sticky carry out of the top bit |
| iter_cnt | output | $clog2(WIDTH+1) | Number of iterations performed |

## Verification
The bench builds two copies of the block. The 8-bit copy runs directed cases: the 0x7F + 0x01 carry run, the all-ones worst case with overflow, a carry-free pair and a zero second operand. It also covers operands disturbed mid-run and hold while idle, with exact iteration counts and busy lengths. The 4-bit copy makes the whole operand space small enough to sweep all 256 pairs. That sweep reaches every carry pattern, including every maximal-length chain, for sum, carry-out and the count bound.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } hfa_state_e;
endpackage

// File: rtl/hfa_slice.sv
// One bit position: a half adder with an input select.
module hfa_slice (
  input  logic ld,
  input  logic ext_a,
  input  logic ext_b,
  input  logic cur_a,
  input  logic cur_b,
  input  logic cin,
  output logic nxt_a,
  output logic nxt_b,
  output logic gen
);
  logic half_sum;

  always_comb begin
    half_sum = cur_a ^ cur_b;
    gen      = cur_a & cur_b;
    nxt_a    = ld ? ext_a : half_sum;
    nxt_b    = ld ? ext_b : cin;
  end
endmodule

// File: rtl/hfa_any.sv
// Completion detector: reports whether any bit of the word is set.
module hfa_any #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any
);
  always_comb any = |vec;
endmodule

// File: rtl/hfa_ctrl.sv
// Start edge detection, run state and iteration counter.
module hfa_ctrl #(
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic             pending,
  output logic             load,
  output logic             step,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  import hfa_pkg::*;

  hfa_state_e state_q;
  logic       start_q;
  logic       start_fall;

  always_comb begin
    start_fall = start_q & ~start_n;
    load       = (state_q == ST_IDLE) & start_fall;
    step       = (state_q == ST_RUN) & pending;
    busy       = (state_q == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      start_q <= 1'b1;
      cnt     <= '0;
    end else begin
      start_q <= start_n;
      case (state_q)
        ST_IDLE: begin
          if (start_fall) begin
            state_q <= ST_RUN;
            cnt     <= '0;
          end
        end
        default: begin
          if (pending) cnt <= cnt + CNT_W'(1);
          else         state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/hfa_adder.sv
// Iterative half-adder feedback adder, one iteration per clock.
module hfa_adder #(
  parameter  int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             busy,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic [CNT_W-1:0] iter_cnt
);
  logic [WIDTH-1:0] acc_a, acc_b;
  logic [WIDTH-1:0] nxt_a, nxt_b, gen;
  logic             load, step, pending, upd;

  hfa_any #(.WIDTH(WIDTH)) det_i (
    .vec (acc_b),
    .any (pending)
  );

  hfa_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .start_n (start_n),
    .pending (pending),
    .load    (load),
    .step    (step),
    .busy    (busy),
    .cnt     (iter_cnt)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic cin_i;
    if (i == 0) begin : g_lsb
      assign cin_i = 1'b0;
    end else begin : g_up
      assign cin_i = gen[i-1];
    end
    hfa_slice slice_i (
      .ld    (load),
      .ext_a (op_a[i]),
      .ext_b (op_b[i]),
      .cur_a (acc_a[i]),
      .cur_b (acc_b[i]),
      .cin   (cin_i),
      .nxt_a (nxt_a[i]),
      .nxt_b (nxt_b[i]),
      .gen   (gen[i])
    );
  end

  assign upd = load | step;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_a <= '0;
      acc_b <= '0;
      cout  <= 1'b0;
    end else begin
      if (upd) begin
        acc_a <= nxt_a;
        acc_b <= nxt_b;
      end
      if (load)      cout <= 1'b0;
      else if (step) cout <= cout | gen[WIDTH-1];
    end
  end

  assign sum = acc_a;
endmodule

// File: rtl/hfa_adder_chk.sv
module hfa_adder_chk #(
  parameter  int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             start_n,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             busy,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [CNT_W-1:0] iter_cnt
);
  logic           st_q;
  logic [WIDTH:0] ref_q;
  logic           ld_seen;

  assign ld_seen = !busy && !start_n && st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= 1'b1;
      ref_q <= '0;
    end else begin
      st_q <= start_n;
      if (ld_seen) ref_q <= {1'b0, op_a} + {1'b0, op_b};
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (rst)
    ld_seen |=> (busy && iter_cnt == '0 && !cout)); // R2
  AST_RESULT_OK: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ({cout, sum} == ref_q)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (iter_cnt == CNT_W'($past(iter_cnt) + 1'b1))); // R5
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || iter_cnt != '0)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_n) |=> ($stable(sum) && $stable(cout) && $stable(iter_cnt))); // R9
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    int'(iter_cnt) <= WIDTH); // R10
endmodule

bind hfa_adder hfa_adder_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .start_n  (start_n),
  .op_a     (op_a),
  .op_b     (op_b),
  .busy     (busy),
  .sum      (sum),
  .cout     (cout),
  .iter_cnt (iter_cnt)
);

// File: tb/hfa_adder_tb_top.sv
module hfa_adder_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;

  logic       start_n = 1'b1;
  logic [7:0] op_a = '0, op_b = '0;
  logic       busy, cout;
  logic [7:0] sum;
  logic [3:0] iter_cnt;

  hfa_adder #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .start_n(start_n), .op_a(op_a), .op_b(op_b),
    .busy(busy), .sum(sum), .cout(cout), .iter_cnt(iter_cnt)
  );

  logic       s4_n = 1'b1;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, cout4;
  logic [3:0] sum4;
  logic [2:0] cnt4;

  hfa_adder #(.WIDTH(4)) dut_w4_i (
    .clk(clk), .rst(rst), .start_n(s4_n), .op_a(a4), .op_b(b4),
    .busy(busy4), .sum(sum4), .cout(cout4), .iter_cnt(cnt4)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic run8(input logic [7:0] a, input logic [7:0] b,
                      output logic [7:0] s, output logic c,
                      output logic [3:0] n, output int cyc);
    @(negedge clk);
    op_a = a; op_b = b; start_n = 1'b0;
    cyc = 0;
    @(negedge clk);
    while (busy && cyc < 100) begin
      cyc++;
      @(negedge clk);
    end
    s = sum; c = cout; n = iter_cnt;
    start_n = 1'b1;
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(sum == 8'h00, "R1", "sum", sum, 0);
    check(cout == 1'b0, "R1", "cout", cout, 0);
    check(iter_cnt == 4'd0, "R1", "iter_cnt", iter_cnt, 0);
  endtask

  task automatic t_load_flags;
    // R2: one cycle after the load edge busy is high, count and carry are clear
    @(negedge clk);
    op_a = 8'h03; op_b = 8'h01; start_n = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R2", "busy after load", busy, 1);
    check(iter_cnt == 4'd0, "R2", "count after load", iter_cnt, 0);
    check(cout == 1'b0, "R2", "cout after load", cout, 0);
    while (busy) @(negedge clk);
    start_n = 1'b1;
  endtask

  task automatic t_long_chain;
    logic [7:0] s; logic c; logic [3:0] n; int cyc;
    run8(8'h7F, 8'h01, s, c, n, cyc);
    check(s == 8'h80, "R3", "7F+01 sum", s, 8'h80);
    check(c == 1'b0, "R4", "7F+01 cout", c, 0);
    check(n == 4'd8, "R5", "7F+01 count", n, 8);
    check(cyc == 9, "R6", "7F+01 busy cycles", cyc, 9);
  endtask

  task automatic t_worst;
    logic [7:0] s; logic c; logic [3:0] n; int cyc;
    run8(8'hFF, 8'h01, s, c, n, cyc);
    check(s == 8'h00, "R3", "FF+01 sum", s, 0);
    check(c == 1'b1, "R4", "FF+01 cout", c, 1);
    check(n == 4'd8, "R10", "FF+01 count", n, 8);
    run8(8'h01, 8'h01, s, c, n, cyc);
    check(s == 8'h02, "R3", "01+01 sum", s, 2);
    check(c == 1'b0, "R4", "cout cleared by load", c, 0);
    check(cyc == int'(n) + 1, "R6", "01+01 busy cycles", cyc, int'(n) + 1);
  endtask

  task automatic t_no_carry;
    logic [7:0] s; logic c; logic [3:0] n; int cyc;
    run8(8'h05, 8'h0A, s, c, n, cyc);
    check(s == 8'h0F, "R3", "05+0A sum", s, 8'h0F);
    check(n == 4'd1, "R5", "05+0A count", n, 1);
    check(cyc == 2, "R6", "05+0A busy cycles", cyc, 2);
  endtask

  task automatic t_zero_b;
    logic [7:0] s; logic c; logic [3:0] n; int cyc;
    run8(8'h3C, 8'h00, s, c, n, cyc);
    check(s == 8'h3C, "R7", "zero b sum", s, 8'h3C);
    check(n == 4'd0, "R7", "zero b count", n, 0);
    check(cyc == 1, "R7", "zero b busy cycles", cyc, 1);
  endtask

  task automatic t_mixed;
    logic [7:0] s; logic c; logic [3:0] n; int cyc;
    run8(8'hC8, 8'h64, s, c, n, cyc);
    check(s == 8'h2C, "R3", "C8+64 sum", s, 8'h2C);
    check(c == 1'b1, "R4", "C8+64 cout", c, 1);
    check(n <= 4'd8, "R10", "C8+64 count bound", n, 8);
  endtask

  task automatic t_ignore_busy;
    int guard = 0;
    @(negedge clk);
    op_a = 8'h7F; op_b = 8'h01; start_n = 1'b0;
    @(negedge clk);
    op_a = 8'h00; op_b = 8'hFF; start_n = 1'b1;
    @(negedge clk);
    start_n = 1'b0;
    op_a = 8'h11;
    while (busy && guard < 100) begin
      guard++;
      @(negedge clk);
    end
    check(sum == 8'h80, "R8", "sum after disturbed run", sum, 8'h80);
    check(iter_cnt == 4'd8, "R8", "count after disturbed run", iter_cnt, 8);
    @(negedge clk);
    check(busy == 1'b0, "R8", "no late restart", busy, 0);
    start_n = 1'b1;
  endtask

  task automatic t_hold;
    logic [7:0] s0; logic c0; logic [3:0] n0;
    @(negedge clk);
    s0 = sum; c0 = cout; n0 = iter_cnt;
    op_a = 8'hAA; op_b = 8'h55;
    repeat (5) @(negedge clk);
    check(sum == s0, "R9", "sum held", sum, s0);
    check(cout == c0, "R9", "cout held", cout, c0);
    check(iter_cnt == n0, "R9", "count held", iter_cnt, n0);
    check(busy == 1'b0, "R9", "busy stays low", busy, 0);
  endtask

  task automatic t_sweep4;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        int guard = 0;
        int exp = a + b;
        @(negedge clk);
        a4 = 4'(a); b4 = 4'(b); s4_n = 1'b0;
        @(negedge clk);
        while (busy4 && guard < 50) begin
          guard++;
          @(negedge clk);
        end
        check({cout4, sum4} == 5'(exp) && cnt4 <= 3'd4, "R3",
              "4-bit sweep {cout,sum}", {cout4, sum4}, exp);
        s4_n = 1'b1;
      end
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_flags();
    t_long_chain();
    t_worst();
    t_no_carry();
    t_zero_b();
    t_mixed();
    t_ignore_busy();
    t_hold();
    t_sweep4();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule